// File: doc/BRIEF.md
# Tile Ring Synchroniser

This block couples one producer pipeline stage to one consumer stage through a ring of fixed-size tile slots kept in on-chip storage. Each side works in two phases. The producer first asks whether a number of slots is free and, once it is told yes, writes tile words into those slots and then commits them with a push. The consumer asks whether a number of tiles is ready, reads them, and then hands the slots back with a pop. The only state shared between the two sides is a pair of tile counts and the two ring pointers.

Both sides see the base address of their current slot, computed from a configurable base plus the slot index times the tile size. Payload words are written and read relative to the side's own pointer, so a producer that was granted N slots addresses them as offsets 0 to N-1. A commit or release that asks for more tiles than the ring can give is refused and leaves a sticky error flag set until reset.

Top module: `tile_ring_sync`

## Requirements
- R1: After reset both pointers are slot 0, the used count is 0, the free count equals SLOTS, both error flags are low, and both slot base outputs equal BASE_ADDR.
- R2: `res_grant` is high in every cycle in which `res_tiles` is less than or equal to the current free count; a request of 0 is always granted.
- R3: `wait_ok` is high in every cycle in which `wait_tiles` is less than or equal to the current used count; on an empty ring any request of 1 or more is held low.
- R4: A push of N tiles with N not above the free count raises the used count by N, lowers the free count by N, and moves the write pointer N slots forward modulo SLOTS, all visible one cycle later.
- R5: A pop of N tiles with N not above the used count lowers the used count by N, raises the free count by N, and moves the read pointer N slots forward modulo SLOTS one cycle later.
- R6: A legal push and a legal pop in the same cycle change the used count by their difference, and the used and free counts always add up to SLOTS.
- R7: A push of more tiles than are free sets `overflow_err`, which stays high until reset; that push moves neither pointer nor count.
- R8: A pop of more tiles than are used sets `underflow_err`, which stays high until reset; that pop moves neither pointer nor count.
- R9: `wr_base_addr` and `rd_base_addr` equal BASE_ADDR plus the write or read pointer times TILE_WORDS.
- R10: A word written with `wr_en` at slot offset k and word index w lands in slot (write pointer + k) mod SLOTS; `rd_data` returns, in the same cycle, the word at slot (read pointer + `rd_slot`) mod SLOTS and index `rd_word`, so tiles reach the consumer in the order they were committed across wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_tiles | input | CNT_W | Producer's requested number of free slots |
| res_grant | output | 1 | Requested free slots are available |
| push_en | input | 1 | Commit written tiles this cycle |
| push_tiles | input | CNT_W | Number of tiles committed |
| wr_en | input | 1 | Write one payload word |
| wr_slot | input | PTR_W | Slot offset from the write pointer |
| wr_word | input | WIDX_W | Word index inside the tile |
| wr_data | input | DATA_W | Payload word |
| wait_tiles | input | CNT_W | Consumer's requested number of ready tiles |
| wait_ok | output | 1 | Requested ready tiles are available |
| pop_en | input | 1 | Release consumed tiles this cycle |
| pop_tiles | input | CNT_W | Number of tiles released |
| rd_slot | input | PTR_W | Slot offset from the read pointer |
| rd_word | input | WIDX_W | Word index inside the tile |
| rd_data | output | DATA_W | Payload word at the read location |
| wr_base_addr | output | ADDR_W | Base address of the current write slot |
| rd_base_addr | output | ADDR_W | Base address of the current read slot |
| tiles_used | output | CNT_W | Tiles committed and not yet released |
| tiles_free | output | CNT_W | Slots available to the producer |
| overflow_err | output | 1 | Sticky: a push exceeded the free count |
| underflow_err | output | 1 | Sticky: a pop exceeded the used count |

## Verification
The bench drives pointers across the wrap point with multi-tile pushes and pops, so a design that advanced by one slot or forgot the modulo would return tiles from the wrong slot and show a wrong base address. It asks for exactly the free or used count and one more, catching an off-by-one comparison that grants a full ring or reports ready on an empty one. Same-cycle push and pop check that one update does not swallow the other, and deliberate over-commit and over-release check that the flags stick while the pointers stay put, where a faulty design would corrupt the counts or drop the flag after one cycle.

// File: rtl/tile_ring_pkg.sv
package tile_ring_pkg;

    // Advance a ring index by a step, wrapping at the slot count.
    function automatic int unsigned ring_step(int unsigned idx, int unsigned step,
                                              int unsigned slots);
        return (idx + step) % slots;
    endfunction

endpackage

// File: rtl/tile_ring_ctrl.sv
module tile_ring_ctrl
    import tile_ring_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int CNT_W = 3,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [CNT_W-1:0] push_tiles,
    input  logic             pop_en,
    input  logic [CNT_W-1:0] pop_tiles,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] used_cnt,
    output logic [CNT_W-1:0] free_cnt,
    output logic             ovf_flag,
    output logic             unf_flag
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] used;
        logic [CNT_W-1:0] free;
        logic             ovf;
        logic             unf;
    } ring_state_t;

    ring_state_t st_d, st_q;
    logic push_ok, pop_ok;
    logic [CNT_W-1:0] add_n, sub_n;

    always_comb begin
        st_d    = st_q;
        push_ok = push_en && (push_tiles <= st_q.free);
        pop_ok  = pop_en  && (pop_tiles  <= st_q.used);
        add_n   = push_ok ? push_tiles : '0;
        sub_n   = pop_ok  ? pop_tiles  : '0;
        if (push_en && !push_ok) st_d.ovf = 1'b1;
        if (pop_en  && !pop_ok)  st_d.unf = 1'b1;
        if (push_ok)
            st_d.wr = PTR_W'(ring_step(32'(st_q.wr), 32'(push_tiles), SLOTS));
        if (pop_ok)
            st_d.rd = PTR_W'(ring_step(32'(st_q.rd), 32'(pop_tiles), SLOTS));
        st_d.used = st_q.used + add_n - sub_n;
        st_d.free = st_q.free - add_n + sub_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr   <= '0;
            st_q.rd   <= '0;
            st_q.used <= '0;
            st_q.free <= CNT_W'(SLOTS);
            st_q.ovf  <= 1'b0;
            st_q.unf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr   = st_q.wr;
    assign rd_ptr   = st_q.rd;
    assign used_cnt = st_q.used;
    assign free_cnt = st_q.free;
    assign ovf_flag = st_q.ovf;
    assign unf_flag = st_q.unf;

    // R6: the two counters are kept separately and must always balance.
    assert_count_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(st_q.used) + 32'(st_q.free)) == SLOTS);

    // R4: pointer gap agrees with the used count (modulo the ring).
    assert_ptr_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(st_q.wr) + SLOTS - 32'(st_q.rd)) % SLOTS) == (32'(st_q.used) % SLOTS));

    // R7: overflow flag is sticky, and a refused push leaves the write pointer alone.
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);
    assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && (push_tiles > st_q.free)) |=> ($stable(st_q.wr) && st_q.ovf));

    // R8: underflow flag is sticky, and a refused pop leaves the read pointer alone.
    assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unf |=> st_q.unf);
    assert_unf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && (pop_tiles > st_q.used)) |=> ($stable(st_q.rd) && st_q.unf));

endmodule

// File: rtl/tile_ring_store.sv
module tile_ring_store #(
    parameter int SLOTS      = 4,
    parameter int TILE_WORDS = 4,
    parameter int DATA_W     = 16,
    parameter int PTR_W      = 2,
    parameter int WIDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_slot_abs,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_slot_abs,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = SLOTS * TILE_WORDS;

    logic [DATA_W-1:0] mem_q [DEPTH];
    int unsigned wr_idx, rd_idx;

    always_comb begin
        wr_idx = (32'(wr_slot_abs) * TILE_WORDS + 32'(wr_word)) % DEPTH;
        rd_idx = (32'(rd_slot_abs) * TILE_WORDS + 32'(rd_word)) % DEPTH;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];

    // R10: a write must target a word inside the tile.
    assert_word_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_word) < TILE_WORDS));

endmodule

// File: rtl/tile_ring_addr.sv
module tile_ring_addr #(
    parameter int          PTR_W      = 2,
    parameter int          ADDR_W     = 16,
    parameter int          TILE_WORDS = 4,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic [PTR_W-1:0]  slot,
    output logic [ADDR_W-1:0] addr
);
    assign addr = BASE + ADDR_W'(32'(slot) * TILE_WORDS);
endmodule

// File: rtl/tile_ring_sync.sv
module tile_ring_sync
    import tile_ring_pkg::*;
#(
    parameter int SLOTS      = 4,
    parameter int TILE_WORDS = 4,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100,
    localparam int CNT_W  = $clog2(SLOTS + 1),
    localparam int PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int WIDX_W = (TILE_WORDS > 1) ? $clog2(TILE_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  res_tiles,
    output logic              res_grant,
    input  logic              push_en,
    input  logic [CNT_W-1:0]  push_tiles,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_slot,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  wait_tiles,
    output logic              wait_ok,
    input  logic              pop_en,
    input  logic [CNT_W-1:0]  pop_tiles,
    input  logic [PTR_W-1:0]  rd_slot,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] wr_base_addr,
    output logic [ADDR_W-1:0] rd_base_addr,
    output logic [CNT_W-1:0]  tiles_used,
    output logic [CNT_W-1:0]  tiles_free,
    output logic              overflow_err,
    output logic              underflow_err
);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] wr_abs, rd_abs;
    logic [PTR_W-1:0] side_ptr [2];
    logic [ADDR_W-1:0] side_addr [2];

    tile_ring_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_tiles(push_tiles),
        .pop_en(pop_en), .pop_tiles(pop_tiles),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .used_cnt(tiles_used), .free_cnt(tiles_free),
        .ovf_flag(overflow_err), .unf_flag(underflow_err)
    );

    assign wr_abs = PTR_W'(ring_step(32'(wr_ptr), 32'(wr_slot), SLOTS));
    assign rd_abs = PTR_W'(ring_step(32'(rd_ptr), 32'(rd_slot), SLOTS));

    tile_ring_store #(.SLOTS(SLOTS), .TILE_WORDS(TILE_WORDS), .DATA_W(DATA_W),
                      .PTR_W(PTR_W), .WIDX_W(WIDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot_abs(wr_abs), .wr_word(wr_word), .wr_data(wr_data),
        .rd_slot_abs(rd_abs), .rd_word(rd_word), .rd_data(rd_data)
    );

    assign side_ptr[0] = wr_ptr;
    assign side_ptr[1] = rd_ptr;

    for (genvar g = 0; g < 2; g++) begin : g_side_addr
        tile_ring_addr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .TILE_WORDS(TILE_WORDS),
                         .BASE(BASE_ADDR)) u_addr (
            .slot(side_ptr[g]), .addr(side_addr[g])
        );
    end

    assign wr_base_addr = side_addr[0];
    assign rd_base_addr = side_addr[1];

    // Level handshakes re-evaluated from the registered counts every cycle.
    assign res_grant = (res_tiles  <= tiles_free);
    assign wait_ok   = (wait_tiles <= tiles_used);

    // R3: nothing is ready on an empty ring.
    assert_empty_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((tiles_used == '0) && (wait_tiles != '0)) |-> !wait_ok);

    // R2: a full ring grants no non-zero reservation.
    assert_full_res_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((tiles_free == '0) && (res_tiles != '0)) |-> !res_grant);

endmodule

// File: tb/tile_ring_sync_test.sv
module tile_ring_sync_test;

    localparam int CLK_PERIOD = 10;
    localparam int S  = 4;
    localparam int TW = 4;
    localparam int BASE = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] res_tiles = '0, push_tiles = '0, wait_tiles = '0, pop_tiles = '0;
    logic push_en = 1'b0, pop_en = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_slot = '0, wr_word = '0, rd_slot = '0, rd_word = '0;
    logic [15:0] wr_data = '0;
    logic res_grant, wait_ok, overflow_err, underflow_err;
    logic [15:0] rd_data, wr_base_addr, rd_base_addr;
    logic [2:0] tiles_used, tiles_free;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_ring_sync uut (
        .clk(clk), .rst_n(rst_n),
        .res_tiles(res_tiles), .res_grant(res_grant),
        .push_en(push_en), .push_tiles(push_tiles),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_word(wr_word), .wr_data(wr_data),
        .wait_tiles(wait_tiles), .wait_ok(wait_ok),
        .pop_en(pop_en), .pop_tiles(pop_tiles),
        .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data),
        .wr_base_addr(wr_base_addr), .rd_base_addr(rd_base_addr),
        .tiles_used(tiles_used), .tiles_free(tiles_free),
        .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    int vecs = 0, fails = 0;
    int m_wr, m_rd, m_used;
    bit m_ovf, m_unf;
    logic [15:0] m_mem [S][TW];
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_addr(int p);
        return BASE + p * TW;
    endfunction

    task automatic model_reset();
        m_wr = 0; m_rd = 0; m_used = 0; m_ovf = 0; m_unf = 0;
    endtask

    task automatic check_state();
        chk("R4/R5 used", int'(tiles_used), m_used);
        chk("R6 free", int'(tiles_free), S - m_used);
        chk("R7 overflow", int'(overflow_err), int'(m_ovf));
        chk("R8 underflow", int'(underflow_err), int'(m_unf));
        chk("R9 wr addr", int'(wr_base_addr), exp_addr(m_wr));
        chk("R9 rd addr", int'(rd_base_addr), exp_addr(m_rd));
    endtask

    // One clock: drive, check level outputs, clock, update model, check state.
    task automatic cycle(bit p, int pn, bit q, int qn, bit we, int ws, int ww,
                         int wd, int rn, int wn, int rs, int rw);
        push_en = p; push_tiles = 3'(pn); pop_en = q; pop_tiles = 3'(qn);
        wr_en = we; wr_slot = 2'(ws); wr_word = 2'(ww); wr_data = 16'(wd);
        res_tiles = 3'(rn); wait_tiles = 3'(wn); rd_slot = 2'(rs); rd_word = 2'(rw);
        #2;
        chk("R2 grant", int'(res_grant), int'(rn <= S - m_used));
        chk("R3 wait", int'(wait_ok), int'(wn <= m_used));
        chk("R10 data", int'(rd_data), int'(m_mem[(m_rd + rs) % S][rw]));
        @(posedge clk);
        begin
            int nu = m_used, nw = m_wr, nr = m_rd;
            if (we) m_mem[(m_wr + ws) % S][ww] = 16'(wd);
            if (p) begin
                if (pn <= S - m_used) begin nu += pn; nw = (m_wr + pn) % S; end
                else m_ovf = 1;
            end
            if (q) begin
                if (qn <= m_used) begin nu -= qn; nr = (m_rd + qn) % S; end
                else m_unf = 1;
            end
            m_used = nu; m_wr = nw; m_rd = nr;
        end
        #1;
        push_en = 0; pop_en = 0; wr_en = 0;
        check_state();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < S; s++)
            for (int w = 0; w < TW; w++) m_mem[s][w] = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 used", int'(tiles_used), 0);
        chk("R1 free", int'(tiles_free), S);
        chk("R1 flags", int'(overflow_err) + int'(underflow_err), 0);
        chk("R1 addr", int'(wr_base_addr), BASE);
        chk("R1 addr rd", int'(rd_base_addr), BASE);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // Fill every slot word; write before the slot is committed (R10).
        for (int s = 0; s < S; s++)
            for (int w = 0; w < TW; w++)
                cycle(0, 0, 0, 0, 1, s, w, 16'h1000 + s * 16 + w, S, 0, 0, 0);
        // R2 / R3 boundaries on empty ring
        cycle(0, 0, 0, 0, 0, 0, 0, 0, S + 1, 1, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R4: commit three tiles, then one more to fill
        cycle(1, 3, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0);
        cycle(1, 1, 0, 0, 0, 0, 0, 0, 1, 3, 2, 1);
        // R3 full ring: request equal to used and one more; R2 full ring
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, S, 3, 3);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, S + 1, 1, 2);
        // R5: release two, write into freed slots, commit across wrap
        cycle(0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 1, 1, 2, 16'hBEEF, 2, 2, 0, 1);
        cycle(1, 2, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0);
        // R6: push and pop in the same cycle
        cycle(0, 0, 1, 3, 0, 0, 0, 0, 0, 4, 3, 2);
        cycle(1, 2, 1, 1, 0, 0, 0, 0, 3, 1, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 1, 2);
        // Random legal traffic
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            int fr = S - m_used;
            int pn = (fr == 0) ? 0 : int'($urandom_range(0, fr));
            int qn = (m_used == 0) ? 0 : int'($urandom_range(0, m_used));
            cycle($urandom_range(0, 1) == 1, pn, $urandom_range(0, 1) == 1, qn,
                  $urandom_range(0, 1) == 1, $urandom_range(0, S - 1),
                  $urandom_range(0, TW - 1), $urandom_range(0, 65535),
                  $urandom_range(0, S + 1), $urandom_range(0, S + 1),
                  $urandom_range(0, S - 1), $urandom_range(0, TW - 1));
        end
        // R7: over-commit, then flag stays while legal traffic continues
        cycle(1, S - m_used + 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: over-release on a drained ring
        cycle(0, 0, 1, m_used, 0, 0, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: reset clears the sticky flags and pointers
        rst_n = 1'b0;
        #2;
        model_reset();
        check_state();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule